// File: doc/BRIEF.md
# Programmable Clock Ratio Enable Generator

The block takes one input clock and a 9-bit ratio configuration word. From these it produces three clock-enable pulse streams: one for the processor core, one for the system bus and one for the peripherals. Each stream pulses once every N input-clock cycles. N comes from a 3-bit code field in the configuration word, looked up in a fixed ratio table. The tables include divide-by-3, divide-by-5 and divide-by-6. Codes outside the valid range fall back to divide-by-8.

The block only produces enables. Downstream logic stays on the input clock and qualifies its registers with the matching enable.

The configuration word is loaded through a single-cycle write strobe and can always be read back. Each write raises a one-cycle notice so that logic timed from the peripheral enable (baud generators, timers) can recompute its own settings. A ratio change never cuts short the period that is already running: each divider picks up its new ratio only when its current count reaches the end.

Top module: `clk_ratio_gen`

## Requirements
- R1: After reset the configuration word reads 0. The core and bus enables are high on every cycle, and the peripheral enable pulses once every 2 cycles.
- R2: When `wr_en` is high on a clock edge, `wr_data` is stored, and `cfg_rd` shows it from the next cycle onward.
- R3: Bits [8:6] select the core ratio. Codes 0..5 give 1, 2, 3, 4, 5 and 8.
- R4: Bits [5:3] select the bus ratio, using the same table as the core.
- R5: Bits [2:0] select the peripheral ratio. Codes 0..4 give 2, 3, 4, 6 and 8.
- R6: Core and bus codes 6 and 7, and peripheral codes 5, 6 and 7, all give a ratio of 8.
- R7: Each enable is high for exactly one cycle out of every N cycles. With N = 1 the enable stays high.
- R8: A new ratio takes effect only when the divider's current count reaches its end, so the period in progress completes at the old length.
- R9: `per_chg` is high for exactly the one cycle after each write, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 9 | New configuration word: core code [8:6], bus code [5:3], peripheral code [2:0] |
| cfg_rd | output | 9 | Configuration word last written |
| cpu_en | output | 1 | Core clock enable |
| bus_en | output | 1 | Bus clock enable |
| per_en | output | 1 | Peripheral clock enable |
| per_chg | output | 1 | One-cycle notice that the configuration was written |

## Verification
The hardest case to reach is a write that lands in the same cycle as a divider's terminal count. This is where a design could either shorten the running period or skip the new ratio. The bench waits for a peripheral pulse at a divide-by-8 setting and writes a divide-by-2 code in that same cycle. It then measures that the next gap is still 8 and that the gap after it is 2. Steady-state ratios for every code, including the out-of-range ones, are measured as pulse intervals after each write has settled.

// File: rtl/clkr_pkg.sv
package clkr_pkg;
  localparam int CODE_W  = 3;
  localparam int NUM_DIV = 3;
  localparam int CFG_W   = CODE_W * NUM_DIV;
  localparam int RATIO_W = 4;

  // core and bus ratio lookup
  function automatic logic [RATIO_W-1:0] fast_ratio(input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = 4'd1;
      3'd1:    r = 4'd2;
      3'd2:    r = 4'd3;
      3'd3:    r = 4'd4;
      3'd4:    r = 4'd5;
      default: r = 4'd8;
    endcase
    return r;
  endfunction

  // peripheral ratio lookup
  function automatic logic [RATIO_W-1:0] slow_ratio(input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = 4'd2;
      3'd1:    r = 4'd3;
      3'd2:    r = 4'd4;
      3'd3:    r = 4'd6;
      default: r = 4'd8;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkr_rst_sync.sv
module clkr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sh_q[STAGES-1];
endmodule

// File: rtl/clkr_divider.sv
module clkr_divider
  import clkr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  output logic               en
);
  localparam int CNT_W = RATIO_W - 1;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [RATIO_W-1:0] reload;
  logic               term;

  assign term   = (cnt_q == '0);
  assign reload = ratio - 1'b1;

  // ratio is sampled only at terminal count
  always_comb begin
    if (term) cnt_d = reload[CNT_W-1:0];
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign en = term;
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import clkr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_rd,
  output logic             cpu_en,
  output logic             bus_en,
  output logic             per_en,
  output logic             per_chg
);
  logic             rst_int_n;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             chg_q, chg_d;
  logic [NUM_DIV-1:0] en_vec;

  clkr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_out_n (rst_int_n)
  );

  always_comb begin
    cfg_d = cfg_q;
    chg_d = 1'b0;
    if (wr_en) begin
      cfg_d = wr_data;
      chg_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q <= '0;
      chg_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      chg_q <= chg_d;
    end
  end

  // index 0: peripheral, 1: bus, 2: core (matches field order)
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    logic [RATIO_W-1:0] ratio;
    if (g == 0) begin : g_slow
      assign ratio = slow_ratio(cfg_q[g*CODE_W +: CODE_W]);
    end else begin : g_fast
      assign ratio = fast_ratio(cfg_q[g*CODE_W +: CODE_W]);
    end
    clkr_divider u_div (
      .clk   (clk),
      .rst_n (rst_int_n),
      .ratio (ratio),
      .en    (en_vec[g])
    );
  end

  assign cfg_rd  = cfg_q;
  assign per_en  = en_vec[0];
  assign bus_en  = en_vec[1];
  assign cpu_en  = en_vec[2];
  assign per_chg = chg_q;
endmodule

// File: rtl/clk_ratio_gen_chk.sv
module clk_ratio_gen_chk
  import clkr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CFG_W-1:0] wr_data,
  input logic [CFG_W-1:0] cfg_rd,
  input logic             cpu_en,
  input logic             per_en,
  input logic             per_chg
);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_rd == $past(wr_data)));

  // R9
  chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> per_chg);

  // R9
  chg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !per_chg);

  // R7
  per_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |=> !per_en);

  // R3
  cpu_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && cfg_rd[8:6] == 3'd0) |=> cpu_en);
endmodule

bind clk_ratio_gen clk_ratio_gen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .cfg_rd  (cfg_rd),
  .cpu_en  (cpu_en),
  .per_en  (per_en),
  .per_chg (per_chg)
);

// File: tb/test_clk_ratio_gen.sv
module test_clk_ratio_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [8:0] wr_data;
  logic [8:0] cfg_rd;
  logic       cpu_en, bus_en, per_en, per_chg;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    stream;
    int    expect_gap;
    string tag;
  } item_t;
  item_t sb_q[$];

  int fast_tab [8] = '{1, 2, 3, 4, 5, 8, 8, 8};
  int slow_tab [8] = '{2, 3, 4, 6, 8, 8, 8, 8};

  int since [3] = '{0, 0, 0};
  int last_gap [3] = '{0, 0, 0};

  always #10 clk = ~clk;

  clk_ratio_gen i_clk_ratio_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_rd(cfg_rd), .cpu_en(cpu_en), .bus_en(bus_en), .per_en(per_en),
    .per_chg(per_chg)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measure pulse intervals and compare against queued expectations
  always @(negedge clk) begin
    logic [2:0] ens;
    ens = {per_en, bus_en, cpu_en};
    for (int s = 0; s < 3; s++) begin
      if (ens[s]) begin
        last_gap[s] = since[s] + 1;
        since[s] = 0;
      end else begin
        since[s]++;
      end
    end
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(last_gap[it.stream] == it.expect_gap, it.tag, last_gap[it.stream], it.expect_gap);
    end
  end

  task automatic write_cfg(input int c, input int b, input int p);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 9'((c << 6) | (b << 3) | p);
    @(negedge clk);
    wr_en = 1'b0;
    check(cfg_rd == 9'((c << 6) | (b << 3) | p), "R2 readback", cfg_rd, (c << 6) | (b << 3) | p);
    check(per_chg == 1'b1, "R9 pulse", per_chg, 1);
    @(negedge clk);
    check(per_chg == 1'b0, "R9 single cycle", per_chg, 0);
  endtask

  // driver: push expected intervals once the new ratios have settled
  task automatic expect_cfg(input int c, input int b, input int p, input string tc, input string tb_, input string tp);
    repeat (24) @(negedge clk);
    sb_q.push_back('{0, fast_tab[c], tc});
    sb_q.push_back('{1, fast_tab[b], tb_});
    sb_q.push_back('{2, slow_tab[p], tp});
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(cfg_rd == 9'd0, "R1 reset cfg", cfg_rd, 0);
    check(per_chg == 1'b0, "R1 reset chg", per_chg, 0);
    check(cpu_en == 1'b1 && bus_en == 1'b1, "R1 full rate", {cpu_en, bus_en}, 3);
    expect_cfg(0, 0, 0, "R1 core", "R1 bus", "R1 per");

    write_cfg(1, 2, 3);
    expect_cfg(1, 2, 3, "R3 core", "R4 bus", "R5 per");
    write_cfg(3, 4, 4);
    expect_cfg(3, 4, 4, "R3 core", "R4 bus", "R5 per");
    write_cfg(5, 0, 1);
    expect_cfg(5, 0, 1, "R3 core", "R4 bus ratio1 R7", "R5 per");
    write_cfg(2, 1, 2);
    expect_cfg(2, 1, 2, "R3 core", "R4 bus", "R5 per");
    write_cfg(6, 7, 5);
    expect_cfg(6, 7, 5, "R6 core", "R6 bus", "R6 per");
    write_cfg(7, 6, 7);
    expect_cfg(7, 6, 7, "R6 core", "R6 bus", "R6 per");
    write_cfg(0, 3, 6);
    expect_cfg(0, 3, 6, "R7 core steady", "R4 bus", "R6 per");

    // R7: one-cycle width at ratio 8
    write_cfg(0, 0, 4);
    repeat (20) @(negedge clk);
    while (!per_en) @(negedge clk);
    @(negedge clk);
    check(per_en == 1'b0, "R7 pulse width", per_en, 0);

    // R8: write in the same cycle as a terminal count
    while (!per_en) @(negedge clk);
    wr_en = 1'b1;
    wr_data = 9'd0;
    @(negedge clk);
    wr_en = 1'b0;
    n = 1;
    while (!per_en) begin
      @(negedge clk);
      n++;
    end
    check(n == 8, "R8 period kept", n, 8);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!per_en);
    check(n == 2, "R8 new ratio", n, 2);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule